// File: doc/BRIEF.md
# Banked Register Access Decoder

This block is the host-facing register front end of a network controller. A host access carries a 4-bit register address, two byte-lane enables and up to 16 bits of data. The lower eight addresses always reach the core control and status registers. The upper eight addresses are steered by a two-bit bank field held in a configuration register. That field selects the station-address page, the multicast hash page or the buffer-memory control page. A fourth bank value is reserved.

An access always covers an even/odd register pair. Lane 0 carries the even register on the low byte and lane 1 carries the odd register on the high byte, so one block serves both 8-bit and 16-bit hosts. The buffer-memory data port sits on the buffer page. It turns host reads into pop strobes and host writes into push strobes towards the buffer memory. It is 16 bits wide when both lanes are enabled and 8 bits wide when only lane 0 is enabled, and a configuration bit swaps the byte order of the 16-bit form. Writing zero to the DMA-enable register clears the DMA end-of-process status bit, and the interrupt that bit raises, in the same stroke.

Top module: `nic_reg_decoder`

## Requirements
- R1: After reset every readable register returns zero, the station-address, hash and DMA-control outputs are zero and `irq` is low.
- R2: Addresses 0 to 7 reach the same eight base registers whatever the bank field holds, and writes to them never alter the station-address or hash bytes.
- R3: With bank 0, addresses 8 to 13 are station-address bytes 0 to 5 (byte k drives `node_id[8k+7:8k]`), and addresses 14 and 15 read the low and high bytes of `tdr_count`.
- R4: With bank 1, addresses 8 to 15 are hash bytes 0 to 7, with byte k driving `hash_bits[8k+7:8k]`.
- R5: With bank 3, addresses 8 to 15 read as zero and writes to them change nothing.
- R6: Address bit 0 is ignored. Lane 0 (`acc_lane[0]`) carries the even register on data bits 7:0 and lane 1 carries the odd register on bits 15:8. A disabled lane reads zero and its register is not written.
- R7: The bank field is bits 3:2 of the register at address 7, which sits on the high lane of the pair at address 6. A new value governs the next access onward.
- R8: With bank 2 and both lanes enabled, address 8 is a 16-bit buffer port. A read raises `buf_pop` and a write raises `buf_push` for exactly the access cycle, with `buf_wide` high. When bit 0 of address 7 is set, the two bytes of the read data and of `buf_wdata` are exchanged; otherwise they pass straight through.
- R9: With bank 2 and only lane 0 enabled, address 8 is an 8-bit port. `buf_wide` is low, the read data is `{8'h00, buf_rdata[7:0]}` and `buf_wdata` is `{8'h00, acc_wdata[7:0]}`. A lane-1-only access to address 9 is reserved: it reads zero and raises no strobe.
- R10: Receive status (address 1) and transmit status (address 0) bits are set by `rx_evt`/`tx_evt` pulses and cleared by writing 1 to them. An event in the same cycle as a clearing write wins.
- R11: Writing 00h to the DMA-enable register (bank 2, address 12) clears receive-status bit 7, the end-of-process flag. A nonzero write leaves it alone, and an end-of-process event in that same cycle wins.
- R12: `irq` is high exactly when some status bit is set together with the matching bit in its enable register (address 2 for transmit, address 3 for receive).
- R13: With bank 2, addresses 10 to 14 are read/write control bytes, 15 reads zero, and `dma_ctl` mirrors address 12.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| acc_stb | input | 1 | One-cycle access strobe |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 4 | Register address |
| acc_lane | input | 2 | Byte-lane enables (bit 0 low byte, bit 1 high byte) |
| acc_wdata | input | 16 | Write data |
| acc_rdata | output | 16 | Read data, valid during the strobe |
| tx_evt | input | 8 | Transmit status set pulses |
| rx_evt | input | 8 | Receive status set pulses, bit 7 = DMA end of process |
| tdr_count | input | 16 | Reflectometry count shown on the station page |
| buf_rdata | input | 16 | Data from buffer memory |
| buf_pop | output | 1 | Buffer read strobe |
| buf_push | output | 1 | Buffer write strobe |
| buf_wide | output | 1 | Current port access is 16-bit |
| buf_wdata | output | 16 | Ordered data to buffer memory |
| node_id | output | 48 | Station address bytes |
| hash_bits | output | 64 | Multicast hash table |
| dma_ctl | output | 8 | DMA-enable register |
| irq | output | 1 | Interrupt request |

## Verification
An end-of-process event on `rx_evt[7]` can arrive in the very cycle the host writes 00h to the DMA-enable register. In the same way, an ordinary status event can coincide with a write-one-to-clear of that same bit. The bench drives the event pulse during the strobe cycle of the clearing write. It then reads the status back through the register port, expecting the bit still set, because the event must not be lost. It also confirms that a later clearing write without the event does drop the bit and `irq`.

// File: rtl/nic_reg_pkg.sv
package nic_reg_pkg;

   // Meaning of the bank field for addresses in the upper half
   typedef enum logic [1:0] {
      BANK_STN  = 2'd0,
      BANK_HASH = 2'd1,
      BANK_BUF  = 2'd2,
      BANK_RSV  = 2'd3
   } bank_e;

endpackage

// File: rtl/nic_slot_decode.sv
// Maps (address, bank) to a flat slot index: the base page first, then one
// page of HALF slots per usable bank. The top bank value has no slots.
module nic_slot_decode #(
   parameter int ADDR_W = 4,
   parameter int BANK_W = 2,
   parameter int SLOT_W = BANK_W + ADDR_W - 1
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [BANK_W-1:0] bank,
   output logic              vld,
   output logic [SLOT_W-1:0] slot
);

   always_comb begin
      if (!addr[ADDR_W-1]) begin
         vld  = 1'b1;
         slot = {{BANK_W{1'b0}}, addr[ADDR_W-2:0]};
      end else if (bank == {BANK_W{1'b1}}) begin
         vld  = 1'b0;
         slot = '0;
      end else begin
         vld  = 1'b1;
         slot = {bank + BANK_W'(1), addr[ADDR_W-2:0]};
      end
   end

endmodule

// File: rtl/nic_w1c_status.sv
// Status byte: event pulses set bits, a clear mask drops them, set wins.
module nic_w1c_status #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] set,
   input  logic [W-1:0] clr,
   output logic [W-1:0] stat
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stat <= '0;
      else        stat <= (stat & ~clr) | set;
   end

endmodule

// File: rtl/nic_bufport.sv
// Byte ordering of the buffer data port for both port widths.
module nic_bufport #(
   parameter int BYTE_W = 8,
   parameter int WORD_W = 2 * BYTE_W
) (
   input  logic              swap,
   input  logic              wide,
   input  logic [WORD_W-1:0] host_wd,
   input  logic [WORD_W-1:0] mem_rd,
   output logic [WORD_W-1:0] mem_wd,
   output logic [WORD_W-1:0] host_rd
);

   always_comb begin
      if (!wide) begin
         mem_wd  = {{BYTE_W{1'b0}}, host_wd[BYTE_W-1:0]};
         host_rd = {{BYTE_W{1'b0}}, mem_rd[BYTE_W-1:0]};
      end else if (swap) begin
         mem_wd  = {host_wd[BYTE_W-1:0], host_wd[WORD_W-1:BYTE_W]};
         host_rd = {mem_rd[BYTE_W-1:0], mem_rd[WORD_W-1:BYTE_W]};
      end else begin
         mem_wd  = host_wd;
         host_rd = mem_rd;
      end
   end

endmodule

// File: rtl/nic_reg_decoder.sv
module nic_reg_decoder #(
   parameter int BYTE_W   = 8,
   parameter int ADDR_W   = 4,
   parameter int BANK_W   = 2,
   parameter int BANK_LSB = 2,
   parameter int SWAP_BIT = 0,
   parameter int EOP_BIT  = 7
) (
   input  logic                                   clk,
   input  logic                                   rst_n,
   input  logic                                   acc_stb,
   input  logic                                   acc_wr,
   input  logic [ADDR_W-1:0]                      acc_addr,
   input  logic [1:0]                             acc_lane,
   input  logic [2*BYTE_W-1:0]                    acc_wdata,
   output logic [2*BYTE_W-1:0]                    acc_rdata,
   input  logic [BYTE_W-1:0]                      tx_evt,
   input  logic [BYTE_W-1:0]                      rx_evt,
   input  logic [2*BYTE_W-1:0]                    tdr_count,
   input  logic [2*BYTE_W-1:0]                    buf_rdata,
   output logic                                   buf_pop,
   output logic                                   buf_push,
   output logic                                   buf_wide,
   output logic [2*BYTE_W-1:0]                    buf_wdata,
   output logic [((1<<(ADDR_W-1))-2)*BYTE_W-1:0]  node_id,
   output logic [(1<<(ADDR_W-1))*BYTE_W-1:0]      hash_bits,
   output logic [BYTE_W-1:0]                      dma_ctl,
   output logic                                   irq
);

   localparam int HALF    = 1 << (ADDR_W - 1);
   localparam int NBANK   = 1 << BANK_W;
   localparam int NSLOT   = HALF * NBANK;
   localparam int SLOT_W  = BANK_W + ADDR_W - 1;
   localparam int WORD_W  = 2 * BYTE_W;
   localparam int NODE_N  = HALF - 2;

   localparam int SL_TXST = 0;
   localparam int SL_RXST = 1;
   localparam int SL_TXIE = 2;
   localparam int SL_RXIE = 3;
   localparam int SL_CFG1 = HALF - 1;
   localparam int SL_NODE = HALF;
   localparam int SL_TDRL = 2 * HALF - 2;
   localparam int SL_TDRH = 2 * HALF - 1;
   localparam int SL_HASH = 2 * HALF;
   localparam int SL_BUF  = 3 * HALF;
   localparam int SL_BUFR = 3 * HALF + 1;
   localparam int SL_DMA  = 3 * HALF + 4;
   localparam int SL_RSV  = 4 * HALF - 1;

   localparam logic [BYTE_W-1:0] EOP_MASK = BYTE_W'(1) << EOP_BIT;

   // elaboration-time parameter checks
   if (BANK_W != 2) begin : g_bad_bank_w
      $error("BANK_W must be 2: three usable pages plus a reserved one");
   end
   if (ADDR_W < 4) begin : g_bad_addr_w
      $error("ADDR_W must be at least 4");
   end
   if (BANK_LSB + BANK_W > BYTE_W) begin : g_bad_bank_lsb
      $error("bank field does not fit the configuration byte");
   end
   if (SWAP_BIT >= BYTE_W || (SWAP_BIT >= BANK_LSB && SWAP_BIT < BANK_LSB + BANK_W)) begin : g_bad_swap
      $error("SWAP_BIT out of range or inside the bank field");
   end
   if (EOP_BIT >= BYTE_W) begin : g_bad_eop
      $error("EOP_BIT out of range");
   end

   logic [1:0]              l_vld;
   logic [1:0]              l_hit;
   logic [SLOT_W-1:0]       l_slot [2];
   logic [BYTE_W-1:0]       l_wd   [2];
   logic [BYTE_W-1:0]       l_rd   [2];
   logic [BYTE_W-1:0]       rd_img [NSLOT];
   logic [BANK_W-1:0]       bank_sel;
   logic                    swap_on;
   logic [BYTE_W-1:0]       tx_stat, rx_stat, tx_ien, rx_ien;
   logic [BYTE_W-1:0]       tx_clr, rx_clr;
   logic                    buf_lo;
   logic                    eop_clr;
   logic [WORD_W-1:0]       bp_host_rd;
   logic                    unused_addr0;

   assign unused_addr0 = acc_addr[0];
   assign bank_sel     = rd_img[SL_CFG1][BANK_LSB +: BANK_W];
   assign swap_on      = rd_img[SL_CFG1][SWAP_BIT];

   // ---------------- per-lane decode and read mux ----------------
   for (genvar l = 0; l < 2; l++) begin : g_lane
      nic_slot_decode #(
         .ADDR_W (ADDR_W),
         .BANK_W (BANK_W),
         .SLOT_W (SLOT_W)
      ) u_dec (
         .addr ({acc_addr[ADDR_W-1:1], 1'(l)}),
         .bank (bank_sel),
         .vld  (l_vld[l]),
         .slot (l_slot[l])
      );

      assign l_hit[l] = acc_stb & acc_lane[l] & l_vld[l];
      assign l_wd[l]  = acc_wdata[l*BYTE_W +: BYTE_W];

      always_comb begin
         if (!l_hit[l])
            l_rd[l] = '0;
         else if (buf_lo && (l == 0 || buf_wide))
            l_rd[l] = bp_host_rd[l*BYTE_W +: BYTE_W];
         else
            l_rd[l] = rd_img[l_slot[l]];
      end

      assign acc_rdata[l*BYTE_W +: BYTE_W] = l_rd[l];
   end

   // ---------------- register slots ----------------
   for (genvar s = 0; s < NSLOT; s++) begin : g_slot
      localparam logic [SLOT_W-1:0] SID = SLOT_W'(s);
      localparam bit IS_RW = !(s == SL_TXST || s == SL_RXST || s == SL_TDRL ||
                               s == SL_TDRH || s == SL_BUF  || s == SL_BUFR ||
                               s == SL_RSV);
      if (IS_RW) begin : g_rw
         logic              wr0, wr1;
         logic [BYTE_W-1:0] q;
         assign wr0 = l_hit[0] & acc_wr & (l_slot[0] == SID);
         assign wr1 = l_hit[1] & acc_wr & (l_slot[1] == SID);
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   q <= '0;
            else if (wr0) q <= l_wd[0];
            else if (wr1) q <= l_wd[1];
         end
         assign rd_img[s] = q;
      end else if (s == SL_TXST) begin : g_txst
         assign rd_img[s] = tx_stat;
      end else if (s == SL_RXST) begin : g_rxst
         assign rd_img[s] = rx_stat;
      end else if (s == SL_TDRL) begin : g_tdrl
         assign rd_img[s] = tdr_count[BYTE_W-1:0];
      end else if (s == SL_TDRH) begin : g_tdrh
         assign rd_img[s] = tdr_count[WORD_W-1:BYTE_W];
      end else begin : g_none
         assign rd_img[s] = '0;
      end
   end

   for (genvar k = 0; k < NODE_N; k++) begin : g_node
      assign node_id[k*BYTE_W +: BYTE_W] = rd_img[SL_NODE + k];
   end
   for (genvar k = 0; k < HALF; k++) begin : g_hash
      assign hash_bits[k*BYTE_W +: BYTE_W] = rd_img[SL_HASH + k];
   end

   assign tx_ien  = rd_img[SL_TXIE];
   assign rx_ien  = rd_img[SL_RXIE];
   assign dma_ctl = rd_img[SL_DMA];

   // ---------------- status and interrupt ----------------
   assign eop_clr = l_hit[0] & acc_wr & (l_slot[0] == SLOT_W'(SL_DMA)) & (l_wd[0] == '0);
   assign tx_clr  = (l_hit[0] & acc_wr & (l_slot[0] == SLOT_W'(SL_TXST))) ? l_wd[0] : '0;
   assign rx_clr  = ((l_hit[1] & acc_wr & (l_slot[1] == SLOT_W'(SL_RXST))) ? l_wd[1] : '0)
                  | (eop_clr ? EOP_MASK : '0);

   nic_w1c_status #(.W(BYTE_W)) u_txst (
      .clk  (clk),
      .rst_n(rst_n),
      .set  (tx_evt),
      .clr  (tx_clr),
      .stat (tx_stat)
   );

   nic_w1c_status #(.W(BYTE_W)) u_rxst (
      .clk  (clk),
      .rst_n(rst_n),
      .set  (rx_evt),
      .clr  (rx_clr),
      .stat (rx_stat)
   );

   assign irq = (|(tx_stat & tx_ien)) | (|(rx_stat & rx_ien));

   // ---------------- buffer data port ----------------
   assign buf_lo   = l_hit[0] & (l_slot[0] == SLOT_W'(SL_BUF));
   assign buf_wide = buf_lo & acc_lane[1];
   assign buf_pop  = buf_lo & ~acc_wr;
   assign buf_push = buf_lo & acc_wr;

   nic_bufport #(.BYTE_W(BYTE_W), .WORD_W(WORD_W)) u_bufport (
      .swap    (swap_on),
      .wide    (buf_wide),
      .host_wd (acc_wdata),
      .mem_rd  (buf_rdata),
      .mem_wd  (buf_wdata),
      .host_rd (bp_host_rd)
   );

endmodule

// File: rtl/nic_reg_decoder_chk.sv
module nic_reg_decoder_chk
   import nic_reg_pkg::*;
#(
   parameter int BYTE_W  = 8,
   parameter int ADDR_W  = 4,
   parameter int BANK_W  = 2,
   parameter int EOP_BIT = 7,
   parameter int NODE_W  = ((1 << (ADDR_W-1)) - 2) * BYTE_W,
   parameter int HASH_W  = (1 << (ADDR_W-1)) * BYTE_W
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 acc_stb,
   input logic                 acc_wr,
   input logic [ADDR_W-1:0]    acc_addr,
   input logic [1:0]           acc_lane,
   input logic [2*BYTE_W-1:0]  acc_wdata,
   input logic [2*BYTE_W-1:0]  acc_rdata,
   input logic [BYTE_W-1:0]    rx_evt,
   input logic                 buf_pop,
   input logic                 buf_push,
   input logic [NODE_W-1:0]    node_id,
   input logic [HASH_W-1:0]    hash_bits,
   input logic [BYTE_W-1:0]    dma_ctl,
   input logic                 irq,
   input logic [BANK_W-1:0]    bank,
   input logic [BYTE_W-1:0]    rx_stat,
   input logic [BYTE_W-1:0]    rx_ien
);

   logic upper, rsv_bank, dma_zero_wr;
   assign upper       = acc_addr[ADDR_W-1];
   assign rsv_bank    = (bank == BANK_W'(BANK_RSV));
   assign dma_zero_wr = acc_stb && acc_wr && upper && (bank == BANK_W'(BANK_BUF)) &&
                        ({acc_addr[ADDR_W-2:1], 1'b0} == (ADDR_W-1)'(4)) &&
                        acc_lane[0] && (acc_wdata[BYTE_W-1:0] == '0);

   // R2
   base_write_keeps_pages_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_stb && acc_wr && !upper) |=> ($stable(node_id) && $stable(hash_bits)));

   // R5
   rsv_bank_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_stb && !acc_wr && upper && rsv_bank) |-> (acc_rdata == '0));

   // R5
   rsv_bank_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_stb && acc_wr && upper && rsv_bank) |=>
      ($stable(node_id) && $stable(hash_bits) && $stable(dma_ctl)));

   // R8
   pop_only_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      buf_pop |-> (acc_stb && !acc_wr && acc_lane[0]));

   // R9
   push_needs_low_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
      buf_push |-> (acc_stb && acc_wr && acc_lane[0]));

   // R11
   eop_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dma_zero_wr && !rx_evt[EOP_BIT]) |=> !rx_stat[EOP_BIT]);

   // R12
   irq_raised_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (((rx_evt & rx_ien) != '0) && !(acc_stb && acc_wr)) |=> irq);

endmodule

bind nic_reg_decoder nic_reg_decoder_chk #(
   .BYTE_W  (BYTE_W),
   .ADDR_W  (ADDR_W),
   .BANK_W  (BANK_W),
   .EOP_BIT (EOP_BIT)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .acc_stb   (acc_stb),
   .acc_wr    (acc_wr),
   .acc_addr  (acc_addr),
   .acc_lane  (acc_lane),
   .acc_wdata (acc_wdata),
   .acc_rdata (acc_rdata),
   .rx_evt    (rx_evt),
   .buf_pop   (buf_pop),
   .buf_push  (buf_push),
   .node_id   (node_id),
   .hash_bits (hash_bits),
   .dma_ctl   (dma_ctl),
   .irq       (irq),
   .bank      (bank_sel),
   .rx_stat   (rx_stat),
   .rx_ien    (rx_ien)
);

// File: tb/test_nic_reg_decoder.sv
`timescale 1ns/1ps
module test_nic_reg_decoder;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        acc_stb = 1'b0;
   logic        acc_wr = 1'b0;
   logic [3:0]  acc_addr = '0;
   logic [1:0]  acc_lane = '0;
   logic [15:0] acc_wdata = '0;
   logic [15:0] acc_rdata;
   logic [7:0]  tx_evt = '0;
   logic [7:0]  rx_evt = '0;
   logic [15:0] tdr_count = 16'hBEEF;
   logic [15:0] buf_rdata = 16'h1234;
   logic        buf_pop, buf_push, buf_wide;
   logic [15:0] buf_wdata;
   logic [47:0] node_id;
   logic [63:0] hash_bits;
   logic [7:0]  dma_ctl;
   logic        irq;

   int n_cmp = 0;
   int n_bad = 0;

   logic [15:0] r_data;
   logic        r_pop, r_push, r_wide;
   logic [15:0] r_bwd;

   always #4 clk = ~clk;

   nic_reg_decoder i_nic_reg_decoder (
      .clk(clk), .rst_n(rst_n), .acc_stb(acc_stb), .acc_wr(acc_wr),
      .acc_addr(acc_addr), .acc_lane(acc_lane), .acc_wdata(acc_wdata),
      .acc_rdata(acc_rdata), .tx_evt(tx_evt), .rx_evt(rx_evt),
      .tdr_count(tdr_count), .buf_rdata(buf_rdata), .buf_pop(buf_pop),
      .buf_push(buf_push), .buf_wide(buf_wide), .buf_wdata(buf_wdata),
      .node_id(node_id), .hash_bits(hash_bits), .dma_ctl(dma_ctl), .irq(irq)
   );

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   // one access cycle; results captured mid-cycle, returns at the next negedge
   task automatic acc(input logic wr, input logic [3:0] a, input logic [1:0] ln,
                      input logic [15:0] wd, input logic [7:0] ev);
      @(negedge clk);
      acc_stb = 1'b1; acc_wr = wr; acc_addr = a; acc_lane = ln; acc_wdata = wd; rx_evt = ev;
      #2;
      r_data = acc_rdata; r_pop = buf_pop; r_push = buf_push;
      r_wide = buf_wide;  r_bwd = buf_wdata;
      @(negedge clk);
      acc_stb = 1'b0; acc_wr = 1'b0; acc_lane = 2'b00; acc_wdata = '0; rx_evt = '0;
   endtask

   task automatic set_cfg1(input logic [7:0] v);
      acc(1'b1, 4'd6, 2'b10, {v, 8'h00}, 8'h00);
   endtask

   task automatic t_reset();
      acc(1'b0, 4'd0, 2'b11, 16'h0, 8'h00); chk("R1 status", r_data, 16'h0);
      acc(1'b0, 4'd6, 2'b11, 16'h0, 8'h00); chk("R1 config", r_data, 16'h0);
      chk("R1 node", node_id, 48'h0);
      chk("R1 hash", hash_bits, 64'h0);
      chk("R1 irq", irq, 1'b0);
   endtask

   task automatic t_station();
      set_cfg1(8'h00);
      acc(1'b1, 4'd8,  2'b11, 16'h2211, 8'h00);
      acc(1'b1, 4'd10, 2'b11, 16'h4433, 8'h00);
      acc(1'b1, 4'd12, 2'b11, 16'h6655, 8'h00);
      chk("R3 node bytes", node_id, 48'h665544332211);
      acc(1'b0, 4'd14, 2'b11, 16'h0, 8'h00);
      chk("R3 tdr read", r_data, 16'hBEEF);
   endtask

   task automatic t_lanes();
      acc(1'b1, 4'd9, 2'b01, 16'hFFAA, 8'h00);
      chk("R6 low lane write", node_id, 48'h6655443322AA);
      acc(1'b0, 4'd8, 2'b10, 16'h0, 8'h00);
      chk("R6 high lane read", r_data, 16'h2200);
      acc(1'b0, 4'd9, 2'b01, 16'h0, 8'h00);
      chk("R6 low lane read", r_data, 16'h00AA);
   endtask

   task automatic t_banks();
      acc(1'b1, 4'd4, 2'b11, 16'hA55A, 8'h00);
      set_cfg1(8'h04);
      acc(1'b0, 4'd4, 2'b11, 16'h0, 8'h00);
      chk("R2 base in bank1", r_data, 16'hA55A);
      acc(1'b1, 4'd8,  2'b11, 16'h2211, 8'h00);
      chk("R7 bank1 write keeps node", node_id, 48'h6655443322AA);
      acc(1'b1, 4'd10, 2'b11, 16'h4433, 8'h00);
      acc(1'b1, 4'd12, 2'b11, 16'h6655, 8'h00);
      acc(1'b1, 4'd14, 2'b11, 16'h8877, 8'h00);
      chk("R4 hash bytes", hash_bits, 64'h8877665544332211);
      acc(1'b0, 4'd14, 2'b11, 16'h0, 8'h00);
      chk("R4 hash read", r_data, 16'h8877);
   endtask

   task automatic t_reserved();
      set_cfg1(8'h0C);
      acc(1'b0, 4'd4, 2'b11, 16'h0, 8'h00);
      chk("R2 base in bank3", r_data, 16'hA55A);
      acc(1'b1, 4'd8,  2'b11, 16'hFFFF, 8'h00);
      acc(1'b1, 4'd14, 2'b11, 16'hFFFF, 8'h00);
      acc(1'b0, 4'd8,  2'b11, 16'h0, 8'h00);
      chk("R5 read zero", r_data, 16'h0);
      chk("R5 hash untouched", hash_bits, 64'h8877665544332211);
      chk("R5 node untouched", node_id, 48'h6655443322AA);
   endtask

   task automatic t_bufword();
      set_cfg1(8'h08);
      acc(1'b0, 4'd8, 2'b11, 16'h0, 8'h00);
      chk("R8 word read", r_data, 16'h1234);
      chk("R8 pop", {r_pop, r_push, r_wide}, 3'b101);
      #1 chk("R8 pop single cycle", buf_pop, 1'b0);
      acc(1'b1, 4'd8, 2'b11, 16'hABCD, 8'h00);
      chk("R8 push", {r_pop, r_push, r_wide}, 3'b011);
      chk("R8 push data", r_bwd, 16'hABCD);
      set_cfg1(8'h09);
      acc(1'b0, 4'd8, 2'b11, 16'h0, 8'h00);
      chk("R8 swapped read", r_data, 16'h3412);
      acc(1'b1, 4'd8, 2'b11, 16'hABCD, 8'h00);
      chk("R8 swapped push", r_bwd, 16'hCDAB);
   endtask

   task automatic t_bufbyte();
      acc(1'b0, 4'd8, 2'b01, 16'h0, 8'h00);
      chk("R9 byte read", r_data, 16'h0034);
      chk("R9 byte pop", {r_pop, r_wide}, 2'b10);
      acc(1'b1, 4'd8, 2'b01, 16'hABCD, 8'h00);
      chk("R9 byte push", {r_push, r_wide}, 2'b10);
      chk("R9 byte data", r_bwd, 16'h00CD);
      acc(1'b0, 4'd9, 2'b10, 16'h0, 8'h00);
      chk("R9 reserved read", {r_data, r_pop}, 17'h0);
      acc(1'b1, 4'd9, 2'b10, 16'hFFFF, 8'h00);
      chk("R9 reserved write", r_push, 1'b0);
   endtask

   task automatic t_ctl();
      acc(1'b1, 4'd10, 2'b11, 16'h2211, 8'h00);
      acc(1'b0, 4'd10, 2'b11, 16'h0, 8'h00);
      chk("R13 ctl readback", r_data, 16'h2211);
      acc(1'b1, 4'd12, 2'b11, 16'h4433, 8'h00);
      chk("R13 dma mirror", dma_ctl, 8'h33);
      acc(1'b0, 4'd12, 2'b11, 16'h0, 8'h00);
      chk("R13 dma readback", r_data, 16'h4433);
      acc(1'b1, 4'd14, 2'b11, 16'hFF55, 8'h00);
      acc(1'b0, 4'd14, 2'b11, 16'h0, 8'h00);
      chk("R13 skip and reserved", r_data, 16'h0055);
   endtask

   task automatic t_status();
      acc(1'b0, 4'd0, 2'b11, 16'h0, 8'h81);
      acc(1'b0, 4'd0, 2'b11, 16'h0, 8'h00);
      chk("R10 set by event", r_data, 16'h8100);
      chk("R12 masked", irq, 1'b0);
      acc(1'b1, 4'd2, 2'b10, 16'h0100, 8'h00);
      chk("R12 enabled", irq, 1'b1);
      acc(1'b1, 4'd0, 2'b10, 16'h0100, 8'h00);
      acc(1'b0, 4'd0, 2'b11, 16'h0, 8'h00);
      chk("R10 write one clears", r_data, 16'h8000);
      chk("R12 drops", irq, 1'b0);
      acc(1'b1, 4'd0, 2'b10, 16'h0100, 8'h01);
      acc(1'b0, 4'd0, 2'b11, 16'h0, 8'h00);
      chk("R10 set wins clear", r_data, 16'h8100);
      acc(1'b1, 4'd0, 2'b10, 16'h0100, 8'h00);
   endtask

   task automatic t_eop();
      set_cfg1(8'h08);
      acc(1'b1, 4'd12, 2'b01, 16'h0005, 8'h00);
      acc(1'b0, 4'd0, 2'b11, 16'h0, 8'h00);
      chk("R11 nonzero keeps eop", r_data, 16'h8000);
      acc(1'b1, 4'd12, 2'b01, 16'h0000, 8'h00);
      acc(1'b0, 4'd0, 2'b11, 16'h0, 8'h00);
      chk("R11 zero clears eop", r_data, 16'h0000);
      acc(1'b1, 4'd12, 2'b01, 16'h0000, 8'h80);
      acc(1'b0, 4'd0, 2'b11, 16'h0, 8'h00);
      chk("R11 event wins clear", r_data, 16'h8000);
      acc(1'b1, 4'd2, 2'b10, 16'h8000, 8'h00);
      chk("R12 eop irq", irq, 1'b1);
      acc(1'b1, 4'd12, 2'b01, 16'h0000, 8'h00);
      chk("R11 irq cleared", irq, 1'b0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_station();
      t_lanes();
      t_banks();
      t_reserved();
      t_bufword();
      t_bufbyte();
      t_ctl();
      t_status();
      t_eop();
      finish_run();
   end

endmodule